// File: doc/BRIEF.md
# Wakeup and Standby Status Controller

This block holds the control and flag state of a low-power controller. Software programs a low-power mode, the flash power-down choices, and a polarity and an enable for each of six external wakeup pins. The CPU then signals that it is entering low power. The block records the mode it entered and sets a sticky flag when that mode was standby or shutdown. It latches one flag for each pin that produced a wakeup edge and raises a wakeup event. That event returns the mode state to run. After the return, the flash-ready status comes back after a fixed recovery delay.

The pins and the internal wakeup line are asynchronous, so each passes through a two-stage synchronizer. Software reads and writes the block through a simple single-cycle register bus. Writes take effect at the clock edge where `req_i && we_i` is true, and read data is combinational from `addr_i`. There are two resets. `por_ni` clears everything. `rst_ni` clears everything except the standby flag.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, every register reads zero except the ready register (0x10), which reads 0x80. In addition, `lp_mode_o` is 0 (run), and `wake_evt_o`, `flash_pd_o` and `pull_apply_o` are 0.
- R2: Register map, by byte address:
  - Mode register (0x00): bits 2:0 are the mode select, bit 3 is stop power-down and bit 5 is sleep power-down.
  - Wake register (0x04): bits 5:0 are the pin enables, bit 10 is pull-apply and bit 15 is the internal-line enable.
  - Polarity register (0x08): bits 5:0.
  - Unimplemented bits read 0. `pull_apply_o` follows bit 10 of the wake register.
- R3: A pin is active when its level XOR its polarity bit is 1. Its flag in status bit n (status register at 0x0C) sets on a rising edge of the active condition while the pin is enabled. The flag becomes visible three clock edges after the pin changes.
- R4: An edge on a disabled pin sets no flag. Enabling a pin that is already active sets no flag.
- R5: Writing 1 to bit n (5:0) of the clear register (0x14) clears pin flag n. When a set and a clear land on the same edge, the set wins. The clear register reads 0, and writes to the status registers have no effect.
- R6: A `lp_req_i` at an edge enters a mode, chosen as follows:
  - With `deep_i`=0 the mode is sleep (1).
  - With `deep_i`=1 and mode-select bit 2 set, the mode is shutdown (4).
  - With `deep_i`=1 and mode select 3'b011, the mode is standby (3).
  - With `deep_i`=1 and any other mode select, the mode is stop (2).
  - `lp_mode_o` shows the mode from that edge on. A request made while `wake_evt_o` is high is ignored.
- R7: Status bit 8 sets on entry to standby or shutdown. Writing 1 to clear-register bit 8 clears it, and so does `por_ni`. It keeps its value through `rst_ni`.
- R8: Status bit 15 follows the synchronized internal line two edges after it changes, whatever the enable. A write to the clear register does not affect it.
- R9: `wake_evt_o` is the OR of the enabled pin flags and, when wake-register bit 15 is set, a one-cycle pulse on a rising edge of the synchronized internal line. While it is high, a low-power mode returns to run at the next edge.
- R10: The following entries drop ready bit 7 and raise `flash_pd_o` at the entry edge:
  - sleep with its power-down bit set;
  - stop with its power-down bit set;
  - standby or shutdown, always.

  When the mode returns to run, `flash_pd_o` falls at that same edge and ready bit 7 returns four edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, asynchronous, active low |
| por_ni | input | 1 | Power-on reset, asynchronous, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| wkup_i | input | 6 | External wakeup pins, asynchronous |
| int_wkup_i | input | 1 | Internal wakeup line, asynchronous |
| lp_req_i | input | 1 | CPU low-power entry request |
| deep_i | input | 1 | Request is deep sleep (1) or sleep (0) |
| wake_evt_o | output | 1 | Wakeup event |
| lp_mode_o | output | 3 | Current mode: 0 run, 1 sleep, 2 stop, 3 standby, 4 shutdown |
| flash_pd_o | output | 1 | Flash power-down request |
| pull_apply_o | output | 1 | Apply configured I/O pulls |

## Verification
Each result has a fixed due time after its stimulus:
- Register writes show on reads from the edge that takes them, and mode entry shows on `lp_mode_o` at the request edge.
- A pin flag is due three edges after the pin moves, and the return to run one edge after that.
- The internal status and its wake pulse are due two edges after the line moves.
- Flash ready is due four edges after the return to run.

The bench drives every input at a falling edge and counts falling edges to each due point. At each due point it checks both the cycle just before, where the old value must still hold, and the cycle itself. This way an extra or a missing register stage fails a check.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [2:0] {
    MODE_RUN   = 3'd0,
    MODE_SLEEP = 3'd1,
    MODE_STOP  = 3'd2,
    MODE_STBY  = 3'd3,
    MODE_SHDN  = 3'd4
  } lp_mode_e;

  // byte offsets
  localparam int OFF_MODE = 'h00;
  localparam int OFF_WAKE = 'h04;
  localparam int OFF_POL  = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_RDY  = 'h10;
  localparam int OFF_CLR  = 'h14;

  // bit positions
  localparam int B_FPD_STOP = 3;
  localparam int B_FPD_SLP  = 5;
  localparam int B_APC      = 10;
  localparam int B_INT_EN   = 15;
  localparam int B_SBF      = 8;
  localparam int B_INT_FLAG = 15;
  localparam int B_RDY      = 7;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lpw_pin_flags.sv
module lpw_pin_flags #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_s_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flag_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic act, act_q, flag_q;

    assign act = pin_s_i[g] ^ pol_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        act_q <= act;
        if (en_i[g] && act && !act_q) flag_q <= 1'b1;  // set beats clear
        else if (clr_i[g])            flag_q <= 1'b0;
      end
    end

    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/lpw_mode_fsm.sv
module lpw_mode_fsm
  import lpw_pkg::*;
#(
  parameter int FLASH_WAKE_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     por_ni,
  input  logic     lp_req_i,
  input  logic     deep_i,
  input  logic [2:0] lpms_i,
  input  logic     fpd_stop_i,
  input  logic     fpd_slp_i,
  input  logic     wake_i,
  input  logic     sbf_clr_i,
  output lp_mode_e mode_o,
  output logic     sbf_o,
  output logic     flash_pd_o,
  output logic     flash_rdy_o
);
  localparam int CNT_W = $clog2(FLASH_WAKE_CYC + 1);

  lp_mode_e   mode_q, mode_d;
  logic       enter, leave, pd_on, sbf_set;
  logic       sbf_q, pd_q, rdy_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    mode_d = mode_q;
    enter  = 1'b0;
    if (mode_q != MODE_RUN) begin
      if (wake_i) mode_d = MODE_RUN;
    end else if (lp_req_i && !wake_i) begin
      enter = 1'b1;
      if (!deep_i)                mode_d = MODE_SLEEP;
      else if (lpms_i[2])         mode_d = MODE_SHDN;
      else if (lpms_i == 3'b011)  mode_d = MODE_STBY;
      else                        mode_d = MODE_STOP;
    end
  end

  assign leave = (mode_q != MODE_RUN) && (mode_d == MODE_RUN);

  always_comb begin
    case (mode_d)
      MODE_SLEEP: pd_on = enter && fpd_slp_i;
      MODE_STOP:  pd_on = enter && fpd_stop_i;
      default:    pd_on = enter;
    endcase
  end

  assign sbf_set = enter && rst_ni && (mode_d == MODE_STBY || mode_d == MODE_SHDN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      pd_q   <= 1'b0;
      rdy_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (pd_on) begin
        pd_q  <= 1'b1;
        rdy_q <= 1'b0;
        cnt_q <= '0;
      end else if (leave && pd_q) begin
        pd_q  <= 1'b0;
        cnt_q <= CNT_W'(FLASH_WAKE_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
      end
    end
  end

  // survives system reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)        sbf_q <= 1'b0;
    else if (sbf_set)   sbf_q <= 1'b1;
    else if (sbf_clr_i) sbf_q <= 1'b0;
  end

  assign mode_o      = mode_q;
  assign sbf_o       = sbf_q;
  assign flash_pd_o  = pd_q;
  assign flash_rdy_o = rdy_q;
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int NUM_PINS       = 6,
  parameter int ADDR_W         = 5,
  parameter int DATA_W         = 32,
  parameter int SYNC_STAGES    = 2,
  parameter int FLASH_WAKE_CYC = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                por_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] wkup_i,
  input  logic                int_wkup_i,
  input  logic                lp_req_i,
  input  logic                deep_i,
  output logic                wake_evt_o,
  output logic [2:0]          lp_mode_o,
  output logic                flash_pd_o,
  output logic                pull_apply_o
);
  logic rst_all_n;
  assign rst_all_n = rst_ni & por_ni;

  logic [2:0]          lpms_q;
  logic                fpd_stop_q, fpd_slp_q, apc_q, int_en_q;
  logic [NUM_PINS-1:0] en_q, pol_q;

  logic wr, wr_mode, wr_wake, wr_pol, wr_clr;
  assign wr      = req_i && we_i;
  assign wr_mode = wr && (addr_i == ADDR_W'(OFF_MODE));
  assign wr_wake = wr && (addr_i == ADDR_W'(OFF_WAKE));
  assign wr_pol  = wr && (addr_i == ADDR_W'(OFF_POL));
  assign wr_clr  = wr && (addr_i == ADDR_W'(OFF_CLR));

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      lpms_q     <= '0;
      fpd_stop_q <= 1'b0;
      fpd_slp_q  <= 1'b0;
      en_q       <= '0;
      apc_q      <= 1'b0;
      int_en_q   <= 1'b0;
      pol_q      <= '0;
    end else begin
      if (wr_mode) begin
        lpms_q     <= wdata_i[2:0];
        fpd_stop_q <= wdata_i[B_FPD_STOP];
        fpd_slp_q  <= wdata_i[B_FPD_SLP];
      end
      if (wr_wake) begin
        en_q     <= wdata_i[NUM_PINS-1:0];
        apc_q    <= wdata_i[B_APC];
        int_en_q <= wdata_i[B_INT_EN];
      end
      if (wr_pol) pol_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  // synchronizers
  logic [NUM_PINS-1:0] pin_s;
  logic                int_s, int_q, int_rise;

  lpw_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_all_n), .d_i(wkup_i), .q_o(pin_s)
  );
  lpw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_int_sync (
    .clk_i(clk_i), .rst_ni(rst_all_n), .d_i(int_wkup_i), .q_o(int_s)
  );

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) int_q <= 1'b0;
    else            int_q <= int_s;
  end
  assign int_rise = int_s && !int_q;

  logic [NUM_PINS-1:0] wuf;
  lpw_pin_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_all_n),
    .pin_s_i(pin_s),
    .pol_i  (pol_q),
    .en_i   (en_q),
    .clr_i  ({NUM_PINS{wr_clr}} & wdata_i[NUM_PINS-1:0]),
    .flag_o (wuf)
  );

  logic wake;
  assign wake = (|(wuf & en_q)) || (int_en_q && int_rise);

  lp_mode_e mode;
  logic     sbf, flash_rdy;

  lpw_mode_fsm #(.FLASH_WAKE_CYC(FLASH_WAKE_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_all_n),
    .por_ni     (por_ni),
    .lp_req_i   (lp_req_i),
    .deep_i     (deep_i),
    .lpms_i     (lpms_q),
    .fpd_stop_i (fpd_stop_q),
    .fpd_slp_i  (fpd_slp_q),
    .wake_i     (wake),
    .sbf_clr_i  (wr_clr && wdata_i[B_SBF]),
    .mode_o     (mode),
    .sbf_o      (sbf),
    .flash_pd_o (flash_pd_o),
    .flash_rdy_o(flash_rdy)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_MODE): begin
        rdata_o[2:0]        = lpms_q;
        rdata_o[B_FPD_STOP] = fpd_stop_q;
        rdata_o[B_FPD_SLP]  = fpd_slp_q;
      end
      ADDR_W'(OFF_WAKE): begin
        rdata_o[NUM_PINS-1:0] = en_q;
        rdata_o[B_APC]        = apc_q;
        rdata_o[B_INT_EN]     = int_en_q;
      end
      ADDR_W'(OFF_POL):  rdata_o[NUM_PINS-1:0] = pol_q;
      ADDR_W'(OFF_STAT): begin
        rdata_o[NUM_PINS-1:0] = wuf;
        rdata_o[B_SBF]        = sbf;
        rdata_o[B_INT_FLAG]   = int_s;
      end
      ADDR_W'(OFF_RDY):  rdata_o[B_RDY] = flash_rdy;
      default:           rdata_o = '0;
    endcase
  end

  assign wake_evt_o   = wake;
  assign lp_mode_o    = mode;
  assign pull_apply_o = apc_q;
endmodule

// File: rtl/lp_wake_ctrl_chk.sv
module lp_wake_ctrl_chk #(
  parameter int NUM_PINS = 6
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic [2:0]          lp_mode_o,
  input logic                wake_evt_o,
  input logic                flash_pd_o,
  input logic                flash_rdy,
  input logic                sbf,
  input logic [NUM_PINS-1:0] wuf,
  input logic                wr_clr
);
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n)
    lp_mode_o <= 3'd4) else $error("mode out of range"); // R6

  AST_NO_ENTRY_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lp_mode_o == 3'd0 && wake_evt_o) |=> lp_mode_o == 3'd0) else $error("entry during wake"); // R6

  AST_WAKE_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lp_mode_o != 3'd0 && wake_evt_o) |=> lp_mode_o == 3'd0) else $error("no return to run"); // R9

  AST_FLAG_FALL_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|(~wuf & $past(wuf))) |-> $past(wr_clr)) else $error("flag fell without clear"); // R5

  AST_SBF_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((lp_mode_o == 3'd3 || lp_mode_o == 3'd4) && $past(lp_mode_o) == 3'd0) |-> sbf)
    else $error("standby flag missing"); // R7

  AST_PD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_n)
    flash_pd_o |-> !flash_rdy) else $error("ready during power-down"); // R10

  AST_PD_ONLY_IN_LP: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(flash_pd_o) |-> lp_mode_o != 3'd0) else $error("power-down in run"); // R10
endmodule

bind lp_wake_ctrl lp_wake_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_all_n),
  .lp_mode_o (lp_mode_o),
  .wake_evt_o(wake_evt_o),
  .flash_pd_o(flash_pd_o),
  .flash_rdy (flash_rdy),
  .sbf       (sbf),
  .wuf       (wuf),
  .wr_clr    (wr_clr)
);

// File: tb/lp_wake_ctrl_tb.sv
module lp_wake_ctrl_tb;
  localparam logic [4:0] A_MODE = 5'h00, A_WAKE = 5'h04, A_POL = 5'h08,
                         A_STAT = 5'h0C, A_RDY  = 5'h10, A_CLR = 5'h14;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [5:0]  wkup_i = '0;
  logic        int_wkup_i = 1'b0, lp_req_i = 1'b0, deep_i = 1'b0;
  logic        wake_evt_o, flash_pd_o, pull_apply_o;
  logic [2:0]  lp_mode_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lp_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wkup_i(wkup_i),
    .int_wkup_i(int_wkup_i), .lp_req_i(lp_req_i), .deep_i(deep_i),
    .wake_evt_o(wake_evt_o), .lp_mode_o(lp_mode_o), .flash_pd_o(flash_pd_o),
    .pull_apply_o(pull_apply_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic enter(logic deep);
    lp_req_i = 1'b1; deep_i = deep;
    @(negedge clk);
    lp_req_i = 1'b0; deep_i = 1'b0;
  endtask

  task automatic sys_reset();
    rst_ni = 1'b0; @(negedge clk); rst_ni = 1'b1; @(negedge clk);
  endtask

  task automatic po_reset();
    por_ni = 1'b0; @(negedge clk); por_ni = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_MODE, d); chk("R1", "mode reg", d, 0);
    rd(A_WAKE, d); chk("R1", "wake reg", d, 0);
    rd(A_POL,  d); chk("R1", "pol reg", d, 0);
    rd(A_STAT, d); chk("R1", "status", d, 0);
    rd(A_RDY,  d); chk("R1", "ready reg", d, 32'h80);
    chk("R1", "mode", lp_mode_o, 0);
    chk("R1", "wake", wake_evt_o, 0);
    chk("R1", "flash_pd", flash_pd_o, 0);
    chk("R1", "pull_apply", pull_apply_o, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_POL, 32'hFFFF_FFFF); rd(A_POL, d); chk("R2", "pol", d, 32'h3F);
    wr(A_POL, 0); cyc(2);
    wr(A_WAKE, 32'hFFFF_FFFF); rd(A_WAKE, d); chk("R2", "wake", d, 32'h843F);
    chk("R2", "pull_apply on", pull_apply_o, 1);
    wr(A_WAKE, 0); chk("R2", "pull_apply off", pull_apply_o, 0);
    wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, d); chk("R2", "mode", d, 32'h2F);
    wr(A_MODE, 0);
  endtask

  task automatic t_pin_flag();
    logic [31:0] d;
    wr(A_POL, 32'h2); wr(A_WAKE, 32'h3); cyc(2);
    wkup_i[0] = 1'b1;
    cyc(2); rd(A_STAT, d); chk("R3", "flag0 early", d[0], 0);
    cyc(1); rd(A_STAT, d); chk("R3", "flag0 set", d[0], 1);
    chk("R9", "wake from flag", wake_evt_o, 1);
    wkup_i[1] = 1'b1;  // inverted pin goes inactive
    cyc(3); rd(A_STAT, d); chk("R3", "flag1 on inactive", d[1], 0);
    wkup_i[1] = 1'b0;
    cyc(3); rd(A_STAT, d); chk("R3", "flag1 inverted", d[1], 1);
    wr(A_CLR, 32'h3); rd(A_STAT, d); chk("R5", "flags cleared", d, 0);
    chk("R9", "wake off", wake_evt_o, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wkup_i[3] = 1'b1;
    cyc(4); rd(A_STAT, d); chk("R4", "disabled pin", d[3], 0);
    chk("R4", "no wake", wake_evt_o, 0);
    wr(A_WAKE, 32'hB);
    cyc(3); rd(A_STAT, d); chk("R4", "enable while active", d[3], 0);
    wkup_i[3] = 1'b0; wr(A_WAKE, 32'h3); cyc(3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wkup_i[0] = 1'b0; cyc(3); wr(A_CLR, 32'h3F);
    wkup_i[0] = 1'b1;
    cyc(2); wr(A_CLR, 32'h1);  // clear lands with the set
    rd(A_STAT, d); chk("R5", "set beats clear", d[0], 1);
    wr(A_STAT, 0); rd(A_STAT, d); chk("R5", "status write ignored", d[0], 1);
    rd(A_CLR, d); chk("R5", "clear reads zero", d, 0);
    wr(A_CLR, 32'h2); rd(A_STAT, d); chk("R5", "other bit no effect", d[0], 1);
    wr(A_CLR, 32'h1); rd(A_STAT, d); chk("R5", "cleared", d[0], 0);
    wr(A_WAKE, 0); wkup_i = '0; cyc(3);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    wr(A_MODE, 32'h1); enter(1'b1);
    chk("R6", "stop", lp_mode_o, 2);
    chk("R10", "stop no pd", flash_pd_o, 0);
    rd(A_STAT, d); chk("R7", "stop no sbf", d[8], 0);
    sys_reset();
    wr(A_MODE, 32'h6); enter(1'b0);
    chk("R6", "sleep", lp_mode_o, 1);
    sys_reset();
    wr(A_MODE, 32'h3); enter(1'b1);
    chk("R6", "standby", lp_mode_o, 3);
    chk("R10", "standby pd", flash_pd_o, 1);
    rd(A_RDY, d);  chk("R10", "standby not ready", d, 0);
    rd(A_STAT, d); chk("R7", "sbf set", d[8], 1);
    sys_reset();
    chk("R7", "run after sys reset", lp_mode_o, 0);
    rd(A_STAT, d); chk("R7", "sbf kept by sys reset", d[8], 1);
    wr(A_CLR, 32'h100); rd(A_STAT, d); chk("R7", "sbf cleared", d[8], 0);
    wr(A_MODE, 32'h6); enter(1'b1);
    chk("R6", "shutdown", lp_mode_o, 4);
    rd(A_STAT, d); chk("R7", "sbf shutdown", d[8], 1);
    po_reset();
    rd(A_STAT, d); chk("R7", "sbf por clear", d[8], 0);
  endtask

  task automatic t_internal();
    logic [31:0] d;
    wr(A_WAKE, 32'h8000); enter(1'b1);
    chk("R6", "stop for internal", lp_mode_o, 2);
    int_wkup_i = 1'b1;
    cyc(1); rd(A_STAT, d); chk("R8", "int early", d[15], 0);
    cyc(1); rd(A_STAT, d); chk("R8", "int flag", d[15], 1);
    chk("R9", "int wake pulse", wake_evt_o, 1);
    chk("R9", "still stop", lp_mode_o, 2);
    cyc(1); chk("R9", "run after int", lp_mode_o, 0);
    chk("R9", "pulse ends", wake_evt_o, 0);
    wr(A_CLR, 32'hFFFF); rd(A_STAT, d); chk("R8", "not sw clearable", d[15], 1);
    int_wkup_i = 1'b0;
    cyc(2); rd(A_STAT, d); chk("R8", "follows line", d[15], 0);
    wr(A_WAKE, 0); enter(1'b1);
    int_wkup_i = 1'b1;
    cyc(4); chk("R9", "disabled int no wake", lp_mode_o, 2);
    rd(A_STAT, d); chk("R8", "status regardless of enable", d[15], 1);
    int_wkup_i = 1'b0; sys_reset(); cyc(2);
  endtask

  task automatic t_flash();
    logic [31:0] d;
    wr(A_WAKE, 32'h1); wr(A_MODE, 32'h8); enter(1'b1);
    chk("R10", "pd on stop", flash_pd_o, 1);
    rd(A_RDY, d); chk("R10", "not ready", d, 0);
    wkup_i[0] = 1'b1;
    cyc(3); chk("R9", "wake", wake_evt_o, 1);
    chk("R9", "stop before return", lp_mode_o, 2);
    cyc(1); chk("R9", "run", lp_mode_o, 0);
    chk("R10", "pd released", flash_pd_o, 0);
    cyc(3); rd(A_RDY, d); chk("R10", "ready at 3", d, 0);
    cyc(1); rd(A_RDY, d); chk("R10", "ready at 4", d, 32'h80);
    enter(1'b1); chk("R6", "entry ignored during wake", lp_mode_o, 0);
  endtask

  initial begin
    cyc(2);
    por_ni = 1'b1; rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_pin_flag();
    t_disabled();
    t_clear();
    t_modes();
    t_internal();
    t_flash();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule